// File: doc/BRIEF.md
# Stack and Subroutine Call Sequencer

This block carries out the stack-touching control-flow operations of a small 8-bit processor core: saving a register on the stack, restoring one from it, a PC-relative subroutine call, a subroutine call through the Z pointer, and a jump through the Z pointer. The core presents a 16-bit opcode together with the current PC and the Z pointer value and raises `start` for one cycle. The sequencer decodes the operation, runs a fixed number of cycles, and uses a byte-wide data-memory port with at most one access per cycle.

The 16-bit stack pointer is held in the block and is visible on `sp` (software sees it as the little-endian byte pair at data addresses 0x5D/0x5E of the core). The stack grows downward: a save writes at SP and then decrements it, and a restore increments SP before it reads. A call stores its return address PC+1 with the low byte at SP and the high byte at SP-1, then lowers SP by two. Register contents pass through a read port (for saves) and a write port (for restores). While `busy` is high the core holds its next fetch; `done` marks the last cycle and qualifies `pc_load`, `pc_next` and `op_cycles`.

Top module: `stack_call_ctrl`

## Requirements
- R1: After reset `busy` is low, `sp` equals the parameter `SP_RESET`, and while `busy` is low there is no memory access, no register write, no `pc_load` and no `done`.
- R2: A save opcode (bits 15:9 = 1001001, bits 3:0 = 1111, register index in bits 8:4) writes the register value to address SP, leaves SP one lower, and keeps `busy` high for exactly 2 cycles.
- R3: A restore opcode (bits 15:9 = 1001000, bits 3:0 = 1111, register index in bits 8:4) reads address SP+1, writes the byte read into the indexed register in its last cycle, leaves SP one higher, and takes 2 cycles.
- R4: A relative call (bits 15:12 = 1101) loads PC+1+k, where k is bits 11:0 as a two's-complement word offset, and takes 4 cycles.
- R5: Both call forms write PC+1 low byte to address SP, then high byte to address SP-1, in that order, and leave SP lower by 2.
- R6: The indirect call opcode 0x9509 loads the Z value as the new PC and takes 3 cycles.
- R7: The indirect jump opcode 0x9409 loads the Z value as the new PC, takes 2 cycles, performs no memory access and leaves SP unchanged.
- R8: No cycle carries both a memory read and a memory write.
- R9: All SP arithmetic wraps modulo 2^16 (a save at SP=0x0000 writes address 0x0000 and leaves SP=0xFFFF; a restore at 0xFFFF reads 0x0000).
- R10: `done` is high in exactly the last `busy` cycle, `op_cycles` then equals the number of `busy` cycles, and `busy` is low in the following cycle.
- R11: `start` with an opcode that is none of the five operations, or `start` while `busy` is high (including the `done` cycle), is ignored: no sequence starts and SP is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Issue the presented opcode |
| opcode | input | 16 | Instruction word |
| pc | input | 16 | Word address of the issued instruction |
| z | input | 16 | Z pointer value |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Last cycle of the sequence |
| op_cycles | output | 3 | Cycle count of the running operation |
| pc_load | output | 1 | Load `pc_next` into the PC (with `done`) |
| pc_next | output | 16 | Branch target |
| sp | output | 16 | Current stack pointer |
| mem_addr | output | 16 | Data-memory byte address |
| mem_we | output | 1 | Data-memory write strobe |
| mem_re | output | 1 | Data-memory read strobe (data next cycle) |
| mem_wdata | output | 8 | Data-memory write byte |
| mem_rdata | input | 8 | Data-memory read byte, one cycle after `mem_re` |
| reg_raddr | output | 5 | Register read index |
| reg_rdata | input | 8 | Register read value |
| reg_we | output | 1 | Register write strobe |
| reg_waddr | output | 5 | Register write index |
| reg_wdata | output | 8 | Register write value |

## Verification
The two events that can share a cycle are the completion of a sequence and a new `start`: the bench keeps `start` asserted from issue through the `done` cycle and then drops it, and judges that exactly one sequence ran and that `busy` is low one cycle later with SP moved only once. A second overlap is the SP update and the access it addresses in the same cycle; the logged write and read addresses are compared against the SP value before the operation, across every register index, all 4096 relative offsets and stack pointers that wrap through zero.

// File: rtl/stk_pkg.sv
package stk_pkg;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_PUSH  = 3'd1,
        OP_POP   = 3'd2,
        OP_RCALL = 3'd3,
        OP_ICALL = 3'd4,
        OP_IJMP  = 3'd5
    } stk_op_e;

    localparam int unsigned IW   = 16;
    localparam int unsigned CYCW = 3;

endpackage

// File: rtl/stk_decode.sv
module stk_decode
    import stk_pkg::*;
(
    input  logic [IW-1:0]   opcode,
    output stk_op_e         op,
    output logic [CYCW-1:0] cyc
);
    localparam logic [IW-1:0] MASK_STK  = 16'hFE0F;
    localparam logic [IW-1:0] PAT_PUSH  = 16'h920F;
    localparam logic [IW-1:0] PAT_POP   = 16'h900F;
    localparam logic [IW-1:0] PAT_ICALL = 16'h9509;
    localparam logic [IW-1:0] PAT_IJMP  = 16'h9409;
    localparam logic [3:0]    PAT_RCALL = 4'hD;

    always_comb begin
        op  = OP_NONE;
        cyc = '0;
        if ((opcode & MASK_STK) == PAT_PUSH) begin
            op  = OP_PUSH;
            cyc = CYCW'(2);
        end else if ((opcode & MASK_STK) == PAT_POP) begin
            op  = OP_POP;
            cyc = CYCW'(2);
        end else if (opcode[IW-1 -: 4] == PAT_RCALL) begin
            op  = OP_RCALL;
            cyc = CYCW'(4);
        end else if (opcode == PAT_ICALL) begin
            op  = OP_ICALL;
            cyc = CYCW'(3);
        end else if (opcode == PAT_IJMP) begin
            op  = OP_IJMP;
            cyc = CYCW'(2);
        end
    end
endmodule

// File: rtl/stk_target.sv
module stk_target
    import stk_pkg::*;
#(
    parameter int unsigned AW = 16,
    parameter int unsigned KW = 12
) (
    input  logic [IW-1:0] opcode,
    input  stk_op_e       op,
    input  logic [AW-1:0] pc,
    input  logic [AW-1:0] z,
    output logic [AW-1:0] ret_addr,
    output logic [AW-1:0] target
);
    localparam int unsigned EXT = AW - KW;

    logic [AW-1:0] offset;

    always_comb begin
        offset   = {{EXT{opcode[KW-1]}}, opcode[KW-1:0]};
        ret_addr = pc + AW'(1);
        target   = (op == OP_RCALL) ? (ret_addr + offset) : z;
    end
endmodule

// File: rtl/stack_call_ctrl.sv
module stack_call_ctrl
    import stk_pkg::*;
#(
    parameter int unsigned AW       = 16,
    parameter int unsigned DW       = 8,
    parameter int unsigned RIW      = 5,
    parameter int unsigned KW       = 12,
    parameter logic [15:0] SP_RESET = 16'h08FF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [15:0]     opcode,
    input  logic [AW-1:0]   pc,
    input  logic [AW-1:0]   z,
    output logic            busy,
    output logic            done,
    output logic [2:0]      op_cycles,
    output logic            pc_load,
    output logic [AW-1:0]   pc_next,
    output logic [AW-1:0]   sp,
    output logic [AW-1:0]   mem_addr,
    output logic            mem_we,
    output logic            mem_re,
    output logic [DW-1:0]   mem_wdata,
    input  logic [DW-1:0]   mem_rdata,
    output logic [RIW-1:0]  reg_raddr,
    input  logic [DW-1:0]   reg_rdata,
    output logic            reg_we,
    output logic [RIW-1:0]  reg_waddr,
    output logic [DW-1:0]   reg_wdata
);
    localparam int unsigned STW     = 2;
    localparam int unsigned RIDX_LO = 4;

    typedef struct packed {
        logic            busy;
        stk_op_e         op;
        logic [STW-1:0]  step;
        logic [STW-1:0]  last;
        logic [CYCW-1:0] cyc;
        logic [RIW-1:0]  ridx;
        logic [AW-1:0]   ret;
        logic [AW-1:0]   tgt;
        logic [AW-1:0]   sp;
    } seq_state_t;

    seq_state_t st_q, st_d;

    stk_op_e         dec_op;
    logic [CYCW-1:0] dec_cyc;
    logic [AW-1:0]   ret_addr;
    logic [AW-1:0]   target;
    logic            fin;

    stk_decode u_decode (
        .opcode (opcode),
        .op     (dec_op),
        .cyc    (dec_cyc)
    );

    stk_target #(.AW(AW), .KW(KW)) u_target (
        .opcode   (opcode),
        .op       (dec_op),
        .pc       (pc),
        .z        (z),
        .ret_addr (ret_addr),
        .target   (target)
    );

    always_comb begin
        st_d      = st_q;
        done      = 1'b0;
        pc_load   = 1'b0;
        mem_addr  = '0;
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        mem_wdata = '0;
        reg_we    = 1'b0;
        reg_wdata = '0;
        fin       = (st_q.step == st_q.last);

        if (!st_q.busy) begin
            if (start && (dec_op != OP_NONE)) begin
                st_d.busy = 1'b1;
                st_d.op   = dec_op;
                st_d.step = '0;
                st_d.last = STW'(dec_cyc - CYCW'(1));
                st_d.cyc  = dec_cyc;
                st_d.ridx = opcode[RIDX_LO +: RIW];
                st_d.ret  = ret_addr;
                st_d.tgt  = target;
            end
        end else begin
            st_d.step = st_q.step + STW'(1);
            unique case (st_q.op)
                OP_PUSH: begin
                    if (st_q.step == STW'(0)) begin
                        mem_we    = 1'b1;
                        mem_addr  = st_q.sp;
                        mem_wdata = reg_rdata;
                        st_d.sp   = st_q.sp - AW'(1);
                    end
                end
                OP_POP: begin
                    if (st_q.step == STW'(0)) begin
                        mem_re   = 1'b1;
                        mem_addr = st_q.sp + AW'(1);
                        st_d.sp  = st_q.sp + AW'(1);
                    end else begin
                        reg_we    = 1'b1;
                        reg_wdata = mem_rdata;
                    end
                end
                OP_RCALL, OP_ICALL: begin
                    if (st_q.step == STW'(0)) begin
                        mem_we    = 1'b1;
                        mem_addr  = st_q.sp;
                        mem_wdata = st_q.ret[DW-1:0];
                    end else if (st_q.step == STW'(1)) begin
                        mem_we    = 1'b1;
                        mem_addr  = st_q.sp - AW'(1);
                        mem_wdata = st_q.ret[AW-1 -: DW];
                        st_d.sp   = st_q.sp - AW'(2);
                    end
                end
                default: begin
                end
            endcase
            if (fin) begin
                done      = 1'b1;
                pc_load   = (st_q.op == OP_RCALL) || (st_q.op == OP_ICALL)
                         || (st_q.op == OP_IJMP);
                st_d.busy = 1'b0;
                st_d.op   = OP_NONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.op   <= OP_NONE;
            st_q.sp   <= AW'(SP_RESET);
        end else begin
            st_q <= st_d;
        end
    end

    assign busy      = st_q.busy;
    assign op_cycles = st_q.cyc;
    assign pc_next   = st_q.tgt;
    assign sp        = st_q.sp;
    assign reg_raddr = st_q.ridx;
    assign reg_waddr = st_q.ridx;

endmodule

// File: rtl/stack_call_ctrl_chk.sv
module stack_call_ctrl_chk #(
    parameter int unsigned AW = 16,
    parameter int unsigned DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic          pc_load,
    input logic          mem_we,
    input logic          mem_re,
    input logic          reg_we,
    input logic [AW-1:0] sp
);
    p_one_access_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_we && !mem_re && !reg_we && !pc_load && !done));

    p_done_ends_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    p_load_with_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |-> done);

    p_restore_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> done);

    p_sp_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((sp == $past(sp)) || (sp == AW'($past(sp) - AW'(1)))
               || (sp == AW'($past(sp) + AW'(1))) || (sp == AW'($past(sp) - AW'(2)))));

    p_sp_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy) |=> (sp == $past(sp)));
endmodule

bind stack_call_ctrl stack_call_ctrl_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .done    (done),
    .pc_load (pc_load),
    .mem_we  (mem_we),
    .mem_re  (mem_re),
    .reg_we  (reg_we),
    .sp      (sp)
);

// File: tb/stack_call_ctrl_tb.sv
`timescale 1ns/1ps
module stack_call_ctrl_tb;
    localparam logic [15:0] SP0 = 16'h0001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] opcode = '0;
    logic [15:0] pc = '0;
    logic [15:0] z = '0;
    logic        busy, done, pc_load, mem_we, mem_re, reg_we;
    logic [2:0]  op_cycles;
    logic [15:0] pc_next, sp, mem_addr;
    logic [7:0]  mem_wdata, mem_rdata, reg_rdata, reg_wdata;
    logic [4:0]  reg_raddr, reg_waddr;

    logic [7:0]  mem [0:255];
    logic [7:0]  regs [0:31];
    logic        tb_we = 1'b0;
    logic [4:0]  tb_wa = '0;
    logic [7:0]  tb_wd = '0;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    int          n_cyc, n_wr, n_rd;
    logic [15:0] wa [0:1];
    logic [7:0]  wd [0:1];
    logic [15:0] ra;
    logic        got_done, got_load;
    logic [15:0] got_pc;
    logic [2:0]  got_cyc;

    always #5 clk = ~clk;

    stack_call_ctrl #(.SP_RESET(SP0)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .pc(pc), .z(z),
        .busy(busy), .done(done), .op_cycles(op_cycles), .pc_load(pc_load),
        .pc_next(pc_next), .sp(sp), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_re(mem_re), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .reg_raddr(reg_raddr), .reg_rdata(reg_rdata), .reg_we(reg_we),
        .reg_waddr(reg_waddr), .reg_wdata(reg_wdata)
    );

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
        if (mem_re) mem_rdata <= mem[mem_addr[7:0]];
        if (reg_we) regs[reg_waddr] <= reg_wdata;
        else if (tb_we) regs[tb_wa] <= tb_wd;
    end
    assign reg_rdata = regs[reg_raddr];

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic set_reg(input logic [4:0] a, input logic [7:0] v);
        @(negedge clk);
        tb_we = 1'b1; tb_wa = a; tb_wd = v;
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    task automatic run(input logic [15:0] op, input logic [15:0] pcv,
                       input logic [15:0] zv, input bit hold);
        @(negedge clk);
        opcode = op; pc = pcv; z = zv; start = 1'b1;
        @(negedge clk);
        if (!hold) start = 1'b0;
        n_cyc = 0; n_wr = 0; n_rd = 0; got_done = 0; got_load = 0;
        got_pc = '0; got_cyc = '0; ra = '0;
        while (busy && n_cyc < 8) begin
            n_cyc++;
            if (mem_we) begin
                if (n_wr < 2) begin wa[n_wr] = mem_addr; wd[n_wr] = mem_wdata; end
                n_wr++;
            end
            if (mem_re) begin ra = mem_addr; n_rd++; end
            if (done) begin
                got_done = 1; got_load = pc_load; got_pc = pc_next; got_cyc = op_cycles;
            end
            @(negedge clk);
        end
        start = 1'b0;
    endtask

    task automatic do_push(input logic [4:0] r);
        logic [15:0] s0;
        logic [7:0]  v;
        s0 = sp; v = regs[r];
        run(16'h920F | (16'(r) << 4), 16'h0100, 16'h0000, 0);
        chk(n_cyc == 2, "R2", "save cycles", n_cyc, 2);
        chk(n_wr == 1 && wa[0] == s0 && wd[0] == v, "R2", "save write addr", wa[0], s0);
        chk(sp == 16'(s0 - 16'd1), "R2", "save sp", sp, 16'(s0 - 16'd1));
        chk(got_done && got_cyc == 3'd2 && !got_load, "R10", "save done/cycles", got_cyc, 2);
    endtask

    task automatic do_pop(input logic [4:0] r, input logic [7:0] expv);
        logic [15:0] s0;
        s0 = sp;
        run(16'h900F | (16'(r) << 4), 16'h0100, 16'h0000, 0);
        chk(n_cyc == 2 && n_wr == 0, "R3", "restore cycles", n_cyc, 2);
        chk(n_rd == 1 && ra == 16'(s0 + 16'd1), "R3", "restore read addr", ra, 16'(s0 + 16'd1));
        chk(regs[r] == expv, "R3", "restored value", regs[r], expv);
        chk(sp == 16'(s0 + 16'd1), "R3", "restore sp", sp, 16'(s0 + 16'd1));
        chk(got_cyc == 3'd2, "R10", "restore op_cycles", got_cyc, 2);
    endtask

    task automatic do_call(input logic [15:0] op, input logic [15:0] pcv,
                           input logic [15:0] zv, input logic [15:0] exp_pc,
                           input int exp_cyc, input string req);
        logic [15:0] s0, r;
        s0 = sp; r = pcv + 16'd1;
        run(op, pcv, zv, 0);
        chk(n_cyc == exp_cyc && got_cyc == 3'(exp_cyc), req, "call cycles", n_cyc, exp_cyc);
        chk(got_load && got_pc == exp_pc, req, "call target", got_pc, exp_pc);
        chk(n_wr == 2 && n_rd == 0 && wa[0] == s0 && wd[0] == r[7:0], "R5",
            "return low byte", {wa[0], wd[0]}, {s0, r[7:0]});
        chk(wa[1] == 16'(s0 - 16'd1) && wd[1] == r[15:8], "R5",
            "return high byte", {wa[1], wd[1]}, {16'(s0 - 16'd1), r[15:8]});
        chk(sp == 16'(s0 - 16'd2), "R5", "call sp", sp, 16'(s0 - 16'd2));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R10 watchdog: actual=hung expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        for (int i = 0; i < 32; i++) regs[i] = 8'(i * 7 + 3);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!busy && !done && !mem_we && !mem_re, "R1", "reset idle", busy, 0);
        chk(sp == SP0, "R1", "reset sp", sp, SP0);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: SP 0x0001 -> 0x0000 -> 0xFFFF, then back through zero
        set_reg(5'd3, 8'hA5);
        set_reg(5'd4, 8'h5C);
        do_push(5'd3);
        do_push(5'd4);
        chk(sp == 16'hFFFF, "R9", "sp wrapped below zero", sp, 16'hFFFF);
        do_pop(5'd10, 8'h5C);
        chk(ra == 16'h0000, "R9", "read wrapped to zero", ra, 0);
        do_pop(5'd11, 8'hA5);
        chk(sp == 16'h0001, "R9", "sp back", sp, 1);

        // R2/R3: every register index through save and restore
        for (int r = 0; r < 32; r++) begin
            logic [7:0] v;
            v = 8'(r * 29 + 11);
            set_reg(5'(r), v);
            do_push(5'(r));
            do_pop(5'((r + 7) % 32), v);
        end

        // R4: all relative offsets
        for (int k = 0; k < 4096; k++) begin
            logic [15:0] pcv, exp;
            pcv = 16'(k * 37) ^ 16'h3C5A;
            exp = pcv + 16'd1 + {{4{k[11]}}, 12'(k)};
            do_call(16'hD000 | 16'(k), pcv, 16'h7777, exp, 4, "R4");
        end

        // R6 / R7: indirect forms across Z and PC patterns
        for (int i = 0; i < 16; i++) begin
            logic [15:0] zv, pcv, s0;
            zv  = 16'(i * 16'h1111) ^ 16'h8001;
            pcv = 16'(i * 16'h0F0F) + 16'hFFF8;
            do_call(16'h9509, pcv, zv, zv, 3, "R6");
            s0 = sp;
            run(16'h9409, pcv, zv, 0);
            chk(n_cyc == 2 && got_cyc == 3'd2, "R7", "jump cycles", n_cyc, 2);
            chk(got_load && got_pc == zv, "R7", "jump target", got_pc, zv);
            chk(n_wr == 0 && n_rd == 0 && sp == s0, "R7", "jump no access", n_wr + n_rd, 0);
        end

        // R11: unknown opcodes
        for (int i = 0; i < 8; i++) begin
            logic [15:0] s0;
            s0 = sp;
            run(16'(i * 16'h1357) & 16'h0FFF, 16'h0010, 16'h0020, 0);
            chk(n_cyc == 0 && sp == s0, "R11", "unknown opcode ignored", n_cyc, 0);
        end

        // R10/R11: start held through the done cycle
        begin
            logic [15:0] s0;
            s0 = sp;
            run(16'h9509, 16'h0200, 16'h0444, 1);
            chk(n_cyc == 3 && got_done, "R10", "held-start sequence length", n_cyc, 3);
            @(negedge clk);
            chk(!busy && sp == 16'(s0 - 16'd2), "R11", "no restart from done cycle", sp,
                16'(s0 - 16'd2));
            s0 = sp;
            run(16'h920F, 16'h0, 16'h0, 1);
            @(negedge clk);
            chk(!busy && sp == 16'(s0 - 16'd1), "R11", "save not repeated", sp,
                16'(s0 - 16'd1));
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule